// File: doc/BRIEF.md
# Modem Status and Request-to-Send Control

This block keeps the modem line status and the modem control settings of a 16550-style serial port. Four active-low modem input pins are passed through a two-flop synchroniser: clear-to-send, data-set-ready, ring indicator and carrier detect. The block reports their asserted levels and latches a change flag for each line. A modem status interrupt is raised while any change flag is set and the interrupt enable input is high. Reading the status register clears every change flag. A change that is detected in the same cycle as the read is kept, not lost.

For the ring line, the change flag marks only the end of a ring: the pin returning high, which means the asserted level falls. The other three lines flag any change. The control register holds three things: a software request-to-send bit, a loop mode bit and an automatic flow-control enable. The active-low `rts_n` output is driven by a three-state source machine. In state `RS_SOFT`, software owns the line and `rts_n` is the inverse of the request bit. In `RS_LOOP`, loop mode forces `rts_n` high. In `RS_THROTTLE`, the receiver's stop request forces `rts_n` high while automatic flow control is enabled.

The machine has these transitions:
- `RS_SOFT`→`RS_LOOP` when loop mode is set.
- `RS_SOFT`→`RS_THROTTLE` when auto flow is enabled and `rx_stop` is high.
- `RS_THROTTLE`→`RS_SOFT` when either of those conditions drops.
- `RS_THROTTLE`→`RS_LOOP` when loop mode is set.
- `RS_LOOP`→`RS_SOFT` or `RS_LOOP`→`RS_THROTTLE` when loop mode clears, depending on the flow condition.

The machine takes the register value being written, so a control write and the state change it causes land on the same clock edge.

Top module: `msc_modem_ctrl`

## Requirements
- R1: After reset, `rts_n` is 1, `irq` is 0, `loop_mode` is 0, the control register reads 0x00 and the status register reads 0x00 while all modem pins are high.
- R2: Status bits 4, 5, 6 and 7 show the asserted (inverted) level of `cts_n`, `dsr_n`, `ri_n` and `dcd_n` respectively. A pin change made before clock edge k is visible after edge k+1 and not after edge k.
- R3: Status bits 0, 1 and 3 set on any change of the CTS, DSR and DCD levels respectively, one edge after the new level becomes visible. They stay set until a status read.
- R4: Status bit 2 sets only when the ring level goes from 1 to 0 (`ri_n` returning high). The ring level going from 0 to 1 sets no flag.
- R5: A status read (`rd_en`=1 with `reg_sel`=1) clears bits 0 to 3 at the clock edge that ends the read. A change detected in that same cycle leaves its bit set.
- R6: `irq` is 1 exactly when `msi_en` is 1 and at least one of status bits 0 to 3 is set.
- R7: A write with `reg_sel`=0 stores bits 1 (request-to-send), 4 (loop) and 5 (auto flow) of `wdata`. Control reads return those bits and 0 elsewhere. A write with `reg_sel`=1 changes nothing.
- R8: Outside loop mode and throttling, `rts_n` is the inverse of control bit 1 from the write edge on.
- R9: While control bit 4 is 1, `rts_n` is 1 from the write edge on, whatever bit 1 holds. `loop_mode` equals control bit 4.
- R10: When control bit 5 is 1 and `rx_stop` is 1, `rts_n` is 1 from the next edge. With bit 5 at 0, `rx_stop` has no effect on `rts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous master reset |
| reg_sel | input | 1 | 0 selects control register, 1 selects status register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags when status is selected) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| msi_en | input | 1 | Modem status interrupt enable |
| rx_stop | input | 1 | Receiver threshold request to stop the far end |
| rts_n | output | 1 | Request-to-send pin, active low |
| loop_mode | output | 1 | Loop mode setting |
| irq | output | 1 | Modem status interrupt request |

## Verification
The control path is walked through the following write sequences:
- request bit alone, which tells the software path apart from the forced states;
- request bit with loop, and request bit with auto flow under stop;
- auto flow disabled under stop, which shows `rx_stop` is gated by the enable;
- every bit written, which shows loop outranks throttling and unused bits read back 0.

On the status side, each pin change is sampled one edge before and one edge after its expected flag so that the synchroniser latency is pinned down. The ring line is driven through both edges to separate the trailing-edge flag from a plain change flag. A read issued in the exact cycle a new change is detected tells a keep-the-edge clear apart from a blind clear.

// File: rtl/msc_pkg.sv
package msc_pkg;
    localparam int NUM_LINES = 4;
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    localparam int CB_RTS  = 1;
    localparam int CB_LOOP = 4;
    localparam int CB_AUTO = 5;
    localparam logic [7:0] CTRL_MASK = 8'h32;

    typedef enum logic [1:0] {
        RS_SOFT     = 2'd0,
        RS_LOOP     = 2'd1,
        RS_THROTTLE = 2'd2
    } rts_state_e;
endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/msc_status.sv
module msc_status
    import msc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic                 rd_clr,
    output logic [7:0]           status_o,
    output logic                 delta_any
);
    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] delta_q;
    logic [NUM_LINES-1:0] change;

    always_comb begin
        change         = level_i ^ prev_q;
        change[LN_RI]  = prev_q[LN_RI] & ~level_i[LN_RI];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= level_i;
            delta_q <= (rd_clr ? '0 : delta_q) | change;
        end
    end

    assign status_o  = {level_i, delta_q};
    assign delta_any = |delta_q;

    // R5: a change seen in a read cycle survives the clear
    assert_edge_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (change != '0) |=> ((delta_q & $past(change)) == $past(change)));
    // R5: a read with no change leaves no flag set
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && change == '0) |=> (delta_q == '0));
    // R4: a rising ring level never sets the ring flag by itself
    assert_ring_lead_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !prev_q[LN_RI] && level_i[LN_RI]) |=> !delta_q[LN_RI]);
endmodule

// File: rtl/msc_rts_ctrl.sv
module msc_rts_ctrl
    import msc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       rx_stop,
    output logic [7:0] ctrl_o,
    output logic       rts_n,
    output logic       loop_mode
);
    logic [7:0]  ctrl_q;
    logic [7:0]  ctrl_d;
    rts_state_e  state_q;
    rts_state_e  state_d;
    logic        throttle;

    assign ctrl_d   = wr_ctrl ? (wdata & CTRL_MASK) : ctrl_q;
    assign throttle = ctrl_d[CB_AUTO] & rx_stop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_SOFT: begin
                if (ctrl_d[CB_LOOP])  state_d = RS_LOOP;
                else if (throttle)    state_d = RS_THROTTLE;
            end
            RS_LOOP: begin
                if (!ctrl_d[CB_LOOP]) state_d = throttle ? RS_THROTTLE : RS_SOFT;
            end
            RS_THROTTLE: begin
                if (ctrl_d[CB_LOOP])  state_d = RS_LOOP;
                else if (!throttle)   state_d = RS_SOFT;
            end
            default:                  state_d = RS_SOFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_SOFT;
            ctrl_q  <= '0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
        end
    end

    always_comb begin
        rts_n     = 1'b1;
        loop_mode = ctrl_q[CB_LOOP];
        unique case (state_q)
            RS_SOFT:     rts_n = ~ctrl_q[CB_RTS];
            RS_LOOP:     rts_n = 1'b1;
            RS_THROTTLE: rts_n = 1'b1;
            default:     rts_n = 1'b1;
        endcase
    end

    assign ctrl_o = ctrl_q;

    // R9: loop mode forces the request line inactive
    assert_loop_forces_rts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_d[CB_LOOP] |=> rts_n);
    // R10: enabled flow stop forces the request line inactive
    assert_throttle_rts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_d[CB_AUTO] && rx_stop) |=> rts_n);
    // R8: with no override, the line follows the software bit
    assert_soft_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_d[CB_LOOP] && !(ctrl_d[CB_AUTO] && rx_stop)) |=> (rts_n == !$past(ctrl_d[CB_RTS])));
endmodule

// File: rtl/msc_modem_ctrl.sv
module msc_modem_ctrl
    import msc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       msi_en,
    input  logic       rx_stop,
    output logic       rts_n,
    output logic       loop_mode,
    output logic       irq
);
    logic [NUM_LINES-1:0] pins_raw;
    logic [NUM_LINES-1:0] pins_sync;
    logic [7:0]           status;
    logic [7:0]           ctrl;
    logic                 delta_any;

    always_comb begin
        pins_raw         = '1;
        pins_raw[LN_CTS] = cts_n;
        pins_raw[LN_DSR] = dsr_n;
        pins_raw[LN_RI]  = ri_n;
        pins_raw[LN_DCD] = dcd_n;
    end

    msc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .pin_o (pins_sync)
    );

    msc_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (~pins_sync),
        .rd_clr    (rd_en & reg_sel),
        .status_o  (status),
        .delta_any (delta_any)
    );

    msc_rts_ctrl u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_en & ~reg_sel),
        .wdata     (wdata),
        .rx_stop   (rx_stop),
        .ctrl_o    (ctrl),
        .rts_n     (rts_n),
        .loop_mode (loop_mode)
    );

    assign rdata = reg_sel ? status : ctrl;
    assign irq   = msi_en & delta_any;

    // R6: interrupt requires both the enable and a pending flag
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msi_en && status[3:0] != 4'h0));
    assert_irq_raised_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en && status[3:0] != 4'h0) |-> irq);
endmodule

// File: tb/test_msc_modem_ctrl.sv
module test_msc_modem_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       msi_en = 1'b0, rx_stop = 1'b0;
    logic       rts_n, loop_mode, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    msc_modem_ctrl i_msc_modem_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .msi_en(msi_en), .rx_stop(rx_stop), .rts_n(rts_n),
        .loop_mode(loop_mode), .irq(irq)
    );

    // {wdata, rx_stop, expected rts_n, expected control readback}
    localparam logic [17:0] VEC [8] = '{
        {8'h02, 1'b0, 1'b0, 8'h02},
        {8'h00, 1'b0, 1'b1, 8'h00},
        {8'h12, 1'b0, 1'b1, 8'h12},
        {8'h22, 1'b1, 1'b1, 8'h22},
        {8'h22, 1'b0, 1'b0, 8'h22},
        {8'h02, 1'b1, 1'b0, 8'h02},
        {8'hFF, 1'b1, 1'b1, 8'h32},
        {8'h32, 1'b0, 1'b1, 8'h32}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] v);
        reg_sel = 1'b1; rd_en = 1'b1;
        #0 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0; reg_sel = 1'b0;
    endtask

    function automatic logic [7:0] peek_status();
        return 8'h00;
    endfunction

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rts_n", {7'h0, rts_n}, 8'h01);
        check("R1 irq", {7'h0, irq}, 8'h00);
        check("R1 loop_mode", {7'h0, loop_mode}, 8'h00);
        reg_sel = 1'b0; #1 check("R1 ctrl", rdata, 8'h00);
        reg_sel = 1'b1; #1 check("R1 status", rdata, 8'h00);
        reg_sel = 1'b0;
        @(negedge clk);

        // R7 R8 R9 R10 vector walk
        for (int k = 0; k < 8; k++) begin
            rx_stop = VEC[k][9];
            wdata = VEC[k][17:10]; reg_sel = 1'b0; wr_en = 1'b1;
            @(posedge clk); @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("R8/R9/R10 rts_n vec%0d", k), {7'h0, rts_n}, {7'h0, VEC[k][8]});
            #1 check($sformatf("R7 ctrl vec%0d", k), rdata, VEC[k][7:0]);
            check($sformatf("R9 loop_mode vec%0d", k), {7'h0, loop_mode}, {7'h0, VEC[k][14]});
            @(negedge clk);
        end
        // R7 status-select write ignored
        wdata = 8'h00; reg_sel = 1'b1; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; reg_sel = 1'b0;
        #1 check("R7 ignored write", rdata, 8'h32);
        rx_stop = 1'b0;
        wdata = 8'h22; wr_en = 1'b1; @(posedge clk); @(negedge clk); wr_en = 1'b0;
        check("R8 soft rts", {7'h0, rts_n}, 8'h00);
        // R10 throttle from next edge
        rx_stop = 1'b1; #1;
        check("R10 before edge", {7'h0, rts_n}, 8'h00);
        cyc(1);
        check("R10 throttled", {7'h0, rts_n}, 8'h01);
        rx_stop = 1'b0; cyc(1);
        check("R10 released", {7'h0, rts_n}, 8'h00);

        // R2 R3 CTS latency and delta
        cts_n = 1'b0;
        cyc(1); reg_sel = 1'b1; #1 check("R2 not yet visible", rdata, 8'h00);
        cyc(1); #1 check("R2 level visible", rdata, 8'h10);
        cyc(1); #1 check("R3 delta cts", rdata, 8'h11);
        check("R6 irq disabled", {7'h0, irq}, 8'h00);
        msi_en = 1'b1; #1 check("R6 irq enabled", {7'h0, irq}, 8'h01);
        read_status(v);
        check("R5 read value", v, 8'h11);
        reg_sel = 1'b1; #1 check("R5 cleared", rdata, 8'h10);
        check("R6 irq cleared", {7'h0, irq}, 8'h00);

        // R4 ring leading edge ignored, trailing edge flagged
        ri_n = 1'b0; cyc(4);
        reg_sel = 1'b1; #1 check("R4 lead ignored", rdata, 8'h50);
        ri_n = 1'b1; cyc(3);
        reg_sel = 1'b1; #1 check("R4 trail flagged", rdata, 8'h14);
        check("R6 irq ring", {7'h0, irq}, 8'h01);
        read_status(v);

        // R5 change in the read cycle is kept (DSR and DCD)
        dsr_n = 1'b0; dcd_n = 1'b0;
        cyc(2);
        read_status(v);
        reg_sel = 1'b1; #1 check("R5 edge kept", rdata, 8'hBA);
        read_status(v);
        reg_sel = 1'b1; #1 check("R3 cleared after", rdata, 8'hB0);
        reg_sel = 1'b0;

        // R1 reset again mid-operation
        rst_n = 1'b0; #1;
        check("R1 reset rts_n", {7'h0, rts_n}, 8'h01);
        check("R1 reset irq", {7'h0, irq}, 8'h00);
        cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1;
        cyc(1); rst_n = 1'b1;
        #1 check("R1 reset ctrl", rdata, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule